// File: doc/BRIEF.md
# SPI EEPROM Frame Sequencer

This block is an SPI master that runs a single access to a small serial EEPROM with a 9-bit byte address. A requester offers a read or a write, together with the address and, for a write, one data byte. The block builds one fixed 24-bit frame and shifts it out in clock mode 0: the serial clock idles low, data is sampled on the rising edge and changes on the falling edge. Once the frame is finished it hands back the received byte.

The frame holds three bytes, sent most significant bit first. The first is the instruction byte, which also carries address bit 8. The second is address bits 7..0. The third is the write data on a write, or zeros on a read. On a read the memory answers during the third byte, so the last eight bits received are the read data. Anything sampled earlier in the frame is dropped.

The request side is a valid/ready port. `req_ready` is high only while the block is idle, and it is the only form of back-pressure. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and the request fields are sampled at that edge. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse, and the consumer must take `rsp_rdata` in that cycle.

Top module: `spi_eeprom_seq`

## Requirements
- R1: `req_ready` is high only while no frame is in progress. A request is taken only when `req_valid` and `req_ready` are both high. A `req_valid` raised while a frame is in progress has no effect on the frame under way or on the next one.
- R2: Each access sends exactly 24 bits on `spi_mosi`, MSB first, in this order: the instruction byte, address bits 7..0, then the third byte. The third byte is `req_wdata` for a write and 8'h00 for a read.
- R3: The instruction byte is 8'h02 for a write and 8'h03 for a read. Address bit 8 is ORed into bit 3 of that byte, which is the fifth bit shifted out.
- R4: `spi_sclk` is low whenever `spi_ss_n` is high. While `spi_ss_n` is low, `spi_mosi` changes only on a falling edge of `spi_sclk` or in the cycle where `spi_ss_n` falls.
- R5: `spi_miso` is sampled at each rising edge of `spi_sclk`. `rsp_rdata` equals the last 8 bits sampled in the frame, with the first of those 8 bits in bit 7.
- R6: With DIV = `CLK_DIV`, each frame has exactly 24 rising edges of `spi_sclk`. The first rising edge comes DIV/2 cycles after `spi_ss_n` falls. The last falling edge comes 48*DIV/2 cycles after `spi_ss_n` falls. `spi_ss_n` stays low for exactly 49*DIV/2 cycles.
- R7: `rsp_valid` is high for exactly one cycle per accepted request, in the first cycle in which `spi_ss_n` is high again.
- R8: `spi_mosi` is low whenever `spi_ss_n` is high.
- R9: After reset, `spi_ss_n` is high, `spi_sclk` and `spi_mosi` are low, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | EEPROM byte address |
| req_wdata | input | 8 | Data byte for a write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last received byte (read data) |
| spi_ss_n | output | 1 | Slave select, active low |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |

## Verification
A wrong bit counter or state register shows at the pins within one frame. Such a fault changes the number of clock edges counted while select is low, or the time from select to the first or last edge, and a model of the memory counts both. A wrong packing or shift order shows up as a frame captured at the memory model that does not match the expected one. A sampling fault shows up as a wrong returned byte when the completion pulse arrives. Handshake faults show up as a ready seen while a frame is in progress, or as a completion pulse that is not exactly one cycle long.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
  localparam int FRAME_W = 24;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 9;
  localparam int A8_POS  = 3;
  localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h02;
  localparam logic [BYTE_W-1:0] OPC_READ  = 8'h03;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOW,
    SQ_HIGH,
    SQ_TRAIL,
    SQ_DONE
  } seq_state_t;
endpackage

// File: rtl/spi_frame_pack.sv
module spi_frame_pack
  import spi_eeprom_pkg::*;
(
  input  logic                   is_write,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BYTE_W-1:0]      wdata,
  output logic [FRAME_W-1:0]     frame
);
  logic [BYTE_W-1:0] opc;

  always_comb begin
    opc = is_write ? OPC_WRITE : OPC_READ;
    opc[A8_POS] = opc[A8_POS] | addr[ADDR_W-1];
    frame = {opc, addr[BYTE_W-1:0], (is_write ? wdata : '0)};
  end
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shreg.sv
module spi_shreg #(
  parameter int W    = 24,
  parameter int TAIL = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [W-1:0]    load_val,
  input  logic            rise,
  input  logic            fall,
  input  logic            sdi,
  output logic            msb,
  output logic [TAIL-1:0] tail
);
  logic [W-1:0] sr;
  logic         rx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      rx_bit <= 1'b0;
    end else if (load) begin
      sr <= load_val;
    end else begin
      if (rise) rx_bit <= sdi;
      if (fall) sr <= {sr[W-2:0], rx_bit};
    end
  end

  assign msb  = sr[W-1];
  assign tail = sr[TAIL-1:0];
endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq
  import spi_eeprom_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              spi_ss_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int BCW = $clog2(FRAME_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_W - 1);

  seq_state_t         state;
  logic [BCW-1:0]     bit_cnt;
  logic               tick, run, take;
  logic               sh_rise, sh_fall, sh_msb;
  logic [FRAME_W-1:0] frame;
  logic [BYTE_W-1:0]  rx_tail;

  assign req_ready = (state == SQ_IDLE);
  assign take      = req_valid && req_ready;
  assign run       = (state == SQ_LOW) || (state == SQ_HIGH) || (state == SQ_TRAIL);
  assign sh_rise   = (state == SQ_LOW) && tick;
  assign sh_fall   = (state == SQ_HIGH) && tick;
  assign rsp_valid = (state == SQ_DONE);
  assign spi_mosi  = !spi_ss_n && sh_msb;

  spi_frame_pack u_pack (
    .is_write (req_write),
    .addr     (req_addr),
    .wdata    (req_wdata),
    .frame    (frame)
  );

  spi_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  spi_shreg #(.W(FRAME_W), .TAIL(BYTE_W)) u_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .load_val (frame),
    .rise     (sh_rise),
    .fall     (sh_fall),
    .sdi      (spi_miso),
    .msb      (sh_msb),
    .tail     (rx_tail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      bit_cnt   <= '0;
      spi_ss_n  <= 1'b1;
      spi_sclk  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (take) begin
          spi_ss_n <= 1'b0;
          bit_cnt  <= '0;
          state    <= SQ_LOW;
        end
        SQ_LOW: if (tick) begin
          spi_sclk <= 1'b1;
          state    <= SQ_HIGH;
        end
        SQ_HIGH: if (tick) begin
          spi_sclk <= 1'b0;
          if (bit_cnt == LAST_BIT) begin
            state <= SQ_TRAIL;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            state   <= SQ_LOW;
          end
        end
        SQ_TRAIL: if (tick) begin
          spi_ss_n  <= 1'b1;
          rsp_rdata <= rx_tail;
          state     <= SQ_DONE;
        end
        SQ_DONE: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_eeprom_seq_chk.sv
module spi_eeprom_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic spi_ss_n,
  input logic spi_sclk,
  input logic spi_mosi
);
  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_ss_n);

  p_sclk_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_ss_n |-> !spi_sclk);

  p_mosi_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_ss_n && $past(!spi_ss_n) && !$fell(spi_sclk)) |-> $stable(spi_mosi));

  p_done_at_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(spi_ss_n));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_mosi_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_ss_n |-> !spi_mosi);
endmodule

bind spi_eeprom_seq spi_eeprom_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .spi_ss_n  (spi_ss_n),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi)
);

// File: tb/sim_spi_eeprom_seq.sv
`timescale 1ns/1ps
module sim_spi_eeprom_seq;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [8:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, spi_ss_n, spi_sclk, spi_mosi;
  logic [7:0] rsp_rdata;
  logic spi_miso = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  spi_eeprom_seq #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .spi_ss_n(spi_ss_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // memory model: drives the pattern MSB first, changing on falling SCLK
  logic [23:0] mem_pat = '0;
  int mem_idx = 23;
  always @(negedge spi_ss_n) begin
    mem_idx = 23;
    spi_miso = mem_pat[23];
  end
  always @(negedge spi_sclk) begin
    if (!spi_ss_n && mem_idx > 0) begin
      mem_idx = mem_idx - 1;
      spi_miso = mem_pat[mem_idx];
    end
  end

  // pin monitor, sampled between clock edges
  int ss_cyc, edges, first_rise, last_fall, idle_viol;
  logic [23:0] cap;
  logic prev_ss = 1'b1, prev_sclk = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!spi_ss_n) begin
        if (prev_ss) begin
          ss_cyc = 0; edges = 0; cap = '0; first_rise = 0; last_fall = 0;
        end
        ss_cyc++;
        if (spi_sclk && !prev_sclk) begin
          if (edges == 0) first_rise = ss_cyc;
          edges++;
          cap = {cap[22:0], spi_mosi};
        end
        if (!spi_sclk && prev_sclk) last_fall = ss_cyc;
      end else begin
        if (spi_sclk) idle_viol++;
        if (spi_mosi) idle_viol++;
      end
      prev_ss = spi_ss_n;
      prev_sclk = spi_sclk;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_frame(input bit wr, input logic [8:0] a, input logic [7:0] d);
    logic [7:0] op;
    op = wr ? 8'h02 : 8'h03;
    if (a[8]) op = op | 8'h08;
    return {op, a[7:0], (wr ? d : 8'h00)};
  endfunction

  task automatic run_access(input bit wr, input logic [8:0] a, input logic [7:0] d,
                            input logic [23:0] pat, input bit poke);
    int wait_cyc;
    bit busy_ready;
    mem_pat = pat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ready = 1'b0;
    if (poke) begin
      // R1: a request offered while busy must be ignored
      req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (req_ready) busy_ready = 1'b1;
      end
      req_valid = 1'b0;
      check(!busy_ready, "R1 ready while busy", busy_ready, 0);
    end
    wait_cyc = 0;
    while (!rsp_valid && wait_cyc < 1000) begin
      @(negedge clk);
      wait_cyc++;
    end
    check(rsp_valid && spi_ss_n, "R7 done with select released", {rsp_valid, spi_ss_n}, 2'b11);
    check(rsp_rdata == pat[7:0], "R5 read byte", rsp_rdata, pat[7:0]);
    check(cap == exp_frame(wr, a, d), "R2/R3 frame on mosi", cap, exp_frame(wr, a, d));
    check(edges == 24, "R6 rising edges", edges, 24);
    check(first_rise == HALF + 1 && last_fall == 48 * HALF + 1,
          "R6 lead/last edge timing", {first_rise[15:0], last_fall[15:0]},
          {16'(HALF + 1), 16'(48 * HALF + 1)});
    check(ss_cyc == 49 * HALF, "R6 select width", ss_cyc, 49 * HALF);
    @(negedge clk);
    check(!rsp_valid, "R7 single-cycle done", rsp_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle_viol = 0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(spi_ss_n && !spi_sclk && !spi_mosi && req_ready && !rsp_valid,
          "R9 reset outputs", {spi_ss_n, spi_sclk, spi_mosi, req_ready, rsp_valid}, 5'b10010);
    rst_n = 1'b1;
    // directed corners: address extremes, A8 set/clear, all-zero/all-one data
    run_access(1'b1, 9'h000, 8'h00, 24'h000000, 1'b0);
    run_access(1'b0, 9'h1FF, 8'h00, 24'hFFFFFF, 1'b0);
    run_access(1'b1, 9'h100, 8'hFF, 24'h5A5AA5, 1'b1);
    run_access(1'b0, 9'h0FF, 8'hAA, 24'h00003C, 1'b1);
    run_access(1'b0, 9'h155, 8'h00, 24'hFFFF81, 1'b0);
    for (int i = 0; i < 30; i++) begin
      run_access(1'($urandom), 9'($urandom), 8'($urandom), 24'($urandom), 1'($urandom));
    end
    // R4/R8: clock and data low whenever select is released
    check(idle_viol == 0, "R4/R8 idle pin levels", idle_viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule